// File: doc/BRIEF.md
# CAN Node Participation and Bus-Off Recovery Controller

This block decides whether a CAN protocol node may take part in bus traffic. It holds the software disconnect flag (here called the hold flag), watches the sampled receive line for bus-idle events, and runs the recovery sequence after the node goes bus-off. An idle event is eleven recessive bits in a row. While the node may not take part, the block forces the transmit pin to the recessive level.

The protocol engine supplies the sampled receive bit with a one-cycle bit strobe and the bit it wants to transmit. The error logic supplies a one-cycle pulse when the node enters bus-off. Software writes the hold flag through a single-bit write port. The block returns a participation enable, the gated transmit pin and a hold status readback. It also returns a pulse that clears the error counters, a load pulse for the receive error counter, and the idle-event count that goes into that counter during recovery. A recovery needs 128 idle events. After that, the node either joins at once or waits for software to release the hold, and then for one further idle event.

Top module: `canRecoveryCtl`

## Requirements
- R1: After reset, holdStatus is 1, busOn is 0, busOff is 0, txOut is 1 and idleCount is 0.
- R2: txOut is 1 whenever busOn is 0. While busOn is 1, txOut equals txIn.
- R3: An idle event is 11 consecutive strobed samples with rxBit=1 (recessive). A strobed sample of 0 (dominant) restarts the run. After an event, the next event needs 11 new recessive samples.
- R4: Suppose the node is not bus-off, holdStatus is 1, and software writes cfgHold=0. The recessive run restarts, and busOn rises one clock after the strobe that completes the first idle event after the write.
- R5: A write of cfgHold=1 while the node is not bus-off drops busOn on the next clock, and holdStatus reads 1.
- R6: A busOffEntry pulse while not bus-off sets busOff and clears busOn on the next clock. On that same clock it pulses errClear for one cycle and sets idleCount to 0. holdStatus reads 1 for the whole bus-off period, even after software writes cfgHold=0. A busOffEntry pulse while already bus-off has no effect.
- R7: During bus-off monitoring, each idle event raises idleCount by 1, with recLoad high for that one cycle. The count stops at 128 and holds until the next bus-off entry.
- R8: If the hold flag is 0 when the 128th idle event is detected, busOff falls and busOn rises on the next clock.
- R9: If the hold flag is 1 when the 128th idle event is detected, the node stays bus-off regardless of further idle events. After software writes cfgHold=0, the run restarts. The node joins one clock after the next completed idle event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitStrobe | input | 1 | One-cycle strobe marking a sampled bus bit |
| rxBit | input | 1 | Sampled receive bit, 1 = recessive |
| txIn | input | 1 | Transmit bit from the protocol engine |
| busOffEntry | input | 1 | Pulse from the error logic on entering bus-off |
| cfgWrEn | input | 1 | Write strobe for the hold flag |
| cfgHold | input | 1 | Hold flag value to write |
| txOut | output | 1 | Transmit pin, forced to 1 while not participating |
| busOn | output | 1 | Node may take part in traffic |
| busOff | output | 1 | Node is in bus-off recovery |
| holdStatus | output | 1 | Readable hold flag, forced to 1 while bus-off |
| errClear | output | 1 | One-cycle pulse clearing both error counters |
| recLoad | output | 1 | Load strobe for the receive error counter |
| idleCount | output | 8 | Idle events counted during recovery |

## Verification
The hardest situation to reach is the end of recovery while the hold flag is still set. Reaching it takes a bus-off entry followed by 128 complete recessive runs. Only after that can the bench test that more idle events do not rejoin the node, and that release needs a new run started after the write. The stimulus drives whole idle events through a bit task and leaves the hold set across all 128. It then feeds extra events, writes the release, and checks the partial runs that follow. Each cycle is compared against a behavioural reference model. A dominant bit placed inside a run and a repeated bus-off pulse during monitoring cover the restart and ignore cases.

// File: rtl/canrec_pkg.sv
package canrec_pkg;

  typedef enum logic [2:0] {
    ST_OFFLINE = 3'd0,
    ST_SYNC    = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_MONITOR = 3'd3,
    ST_WAIT    = 3'd4,
    ST_RESYNC  = 3'd5
  } nodeState_t;

  typedef struct packed {
    logic runClear;
    logic countClear;
    logic countInc;
  } dpCtl_t;

endpackage

// File: rtl/canRecDatapath.sv
module canRecDatapath
  import canrec_pkg::*;
#(
  parameter int IDLE_BITS = 11,
  parameter int EVENTS    = 128,
  parameter int CNT_W     = $clog2(EVENTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStrobe,
  input  logic             rxBit,
  input  dpCtl_t           ctl,
  output logic             idleEvt,
  output logic             atLast,
  output logic [CNT_W-1:0] idleCount,
  output logic             errClear,
  output logic             recLoad
);

  localparam int RUN_W = $clog2(IDLE_BITS);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EVENTS - 1);

  logic [RUN_W-1:0] runCnt;

  assign idleEvt = bitStrobe & rxBit & (runCnt == RUN_LAST) & ~ctl.runClear;
  assign atLast  = (idleCount == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (ctl.runClear) begin
      runCnt <= '0;
    end else if (bitStrobe) begin
      if (!rxBit || runCnt == RUN_LAST) runCnt <= '0;
      else                              runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCount <= '0;
      errClear  <= 1'b0;
      recLoad   <= 1'b0;
    end else begin
      errClear <= ctl.countClear;
      recLoad  <= ctl.countInc & ~ctl.countClear;
      if (ctl.countClear)    idleCount <= '0;
      else if (ctl.countInc) idleCount <= idleCount + 1'b1;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RUN_LAST); // R3
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    idleCount <= CNT_W'(EVENTS)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    errClear |-> idleCount == '0); // R6
  AST_LOAD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    recLoad |-> idleCount != '0); // R7

endmodule

// File: rtl/canRecControl.sv
module canRecControl
  import canrec_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   busOffEntry,
  input  logic   cfgWrEn,
  input  logic   cfgHold,
  input  logic   idleEvt,
  input  logic   atLast,
  output dpCtl_t ctl,
  output logic   busOn,
  output logic   busOff,
  output logic   holdStatus
);

  nodeState_t state, stateNext;
  logic holdFlag, holdEff, accept, releaseWr;

  assign busOn      = (state == ST_ACTIVE);
  assign busOff     = (state == ST_MONITOR) || (state == ST_WAIT) || (state == ST_RESYNC);
  assign holdStatus = holdFlag | busOff;

  assign holdEff   = cfgWrEn ? cfgHold : holdFlag;
  assign accept    = busOffEntry & ~busOff;
  assign releaseWr = cfgWrEn & ~cfgHold & holdFlag;

  always_comb begin
    ctl.runClear   = accept | (releaseWr & ((state == ST_OFFLINE) || (state == ST_WAIT)));
    ctl.countClear = accept;
    ctl.countInc   = (state == ST_MONITOR) & idleEvt;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OFFLINE: if (accept) stateNext = ST_MONITOR;
                  else if (releaseWr) stateNext = ST_SYNC;
      ST_SYNC:    if (accept) stateNext = ST_MONITOR;
                  else if (holdEff) stateNext = ST_OFFLINE;
                  else if (idleEvt) stateNext = ST_ACTIVE;
      ST_ACTIVE:  if (accept) stateNext = ST_MONITOR;
                  else if (holdEff) stateNext = ST_OFFLINE;
      ST_MONITOR: if (idleEvt && atLast) stateNext = holdEff ? ST_WAIT : ST_ACTIVE;
      ST_WAIT:    if (!holdEff) stateNext = ST_RESYNC;
      ST_RESYNC:  if (holdEff) stateNext = ST_WAIT;
                  else if (idleEvt) stateNext = ST_ACTIVE;
      default:    stateNext = ST_OFFLINE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFFLINE;
      holdFlag <= 1'b1;
    end else begin
      state <= stateNext;
      if (accept)       holdFlag <= 1'b1;
      else if (cfgWrEn) holdFlag <= cfgHold;
    end
  end

  AST_JOIN_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOn) |-> $past(idleEvt)); // R4
  AST_HOLD_IN_BUSOFF: assert property (@(posedge clk) disable iff (!rstN)
    busOff |-> holdStatus); // R6
  AST_OFF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    busOff |-> !busOn); // R6
  AST_LEAVE_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOff) |-> busOn); // R8
  AST_HOLD_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgHold && !busOff) |=> !busOn); // R5

endmodule

// File: rtl/canRecoveryCtl.sv
module canRecoveryCtl
  import canrec_pkg::*;
#(
  parameter int IDLE_BITS = 11,
  parameter int EVENTS    = 128,
  parameter int CNT_W     = $clog2(EVENTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStrobe,
  input  logic             rxBit,
  input  logic             txIn,
  input  logic             busOffEntry,
  input  logic             cfgWrEn,
  input  logic             cfgHold,
  output logic             txOut,
  output logic             busOn,
  output logic             busOff,
  output logic             holdStatus,
  output logic             errClear,
  output logic             recLoad,
  output logic [CNT_W-1:0] idleCount
);

  dpCtl_t ctl;
  logic   idleEvt, atLast;

  canRecControl u_ctrl (
    .clk(clk), .rstN(rstN), .busOffEntry(busOffEntry),
    .cfgWrEn(cfgWrEn), .cfgHold(cfgHold),
    .idleEvt(idleEvt), .atLast(atLast), .ctl(ctl),
    .busOn(busOn), .busOff(busOff), .holdStatus(holdStatus)
  );

  canRecDatapath #(.IDLE_BITS(IDLE_BITS), .EVENTS(EVENTS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .rxBit(rxBit),
    .ctl(ctl), .idleEvt(idleEvt), .atLast(atLast),
    .idleCount(idleCount), .errClear(errClear), .recLoad(recLoad)
  );

  assign txOut = busOn ? txIn : 1'b1;

  AST_TX_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    (!busOn || busOff) |-> txOut); // R2

endmodule

// File: tb/canRecoveryCtl_tb.sv
module canRecoveryCtl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitStrobe = 1'b0, rxBit = 1'b1, txIn = 1'b0;
  logic busOffEntry = 1'b0, cfgWrEn = 1'b0, cfgHold = 1'b0;
  logic txOut, busOn, busOff, holdStatus, errClear, recLoad;
  logic [7:0] idleCount;

  int nChecks = 0, nFails = 0, cycles = 0;

  always #10 clk = ~clk;

  canRecoveryCtl u_dut (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .rxBit(rxBit), .txIn(txIn),
    .busOffEntry(busOffEntry), .cfgWrEn(cfgWrEn), .cfgHold(cfgHold),
    .txOut(txOut), .busOn(busOn), .busOff(busOff), .holdStatus(holdStatus),
    .errClear(errClear), .recLoad(recLoad), .idleCount(idleCount)
  );

  // Behavioural reference: mode 0 offline,1 sync,2 active,3 monitor,4 wait,5 resync
  int mMode = 0, mRun = 0, mCnt = 0;
  bit mHold = 1, mErr = 0, mLoad = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mRun = 0; mCnt = 0; mHold = 1; mErr = 0; mLoad = 0;
    end else begin
      bit ev, inOff, acc, clrRun, eff;
      int oldCnt;
      ev = 0; inOff = (mMode >= 3); acc = busOffEntry && !inOff;
      eff = cfgWrEn ? cfgHold : mHold;
      clrRun = acc || (cfgWrEn && !cfgHold && mHold && (mMode == 0 || mMode == 4));
      if (clrRun) mRun = 0;
      else if (bitStrobe) begin
        if (!rxBit) mRun = 0;
        else if (mRun == 10) begin ev = 1; mRun = 0; end
        else mRun++;
      end
      oldCnt = mCnt;
      mErr = acc;
      mLoad = (mMode == 3) && ev;
      if (acc) mCnt = 0; else if (mLoad) mCnt++;
      if (acc) mMode = 3;
      else case (mMode)
        0: if (cfgWrEn && !cfgHold) mMode = 1;
        1: if (eff) mMode = 0; else if (ev) mMode = 2;
        2: if (eff) mMode = 0;
        3: if (ev && oldCnt == 127) mMode = eff ? 4 : 2;
        4: if (!eff) mMode = 5;
        5: if (eff) mMode = 4; else if (ev) mMode = 2;
        default: mMode = 0;
      endcase
      if (acc) mHold = 1; else if (cfgWrEn) mHold = cfgHold;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      bit mOn, mOff;
      mOn = (mMode == 2); mOff = (mMode >= 3);
      check(busOn == mOn, "R4 busOn", busOn, mOn);
      check(busOff == mOff, "R6 busOff", busOff, mOff);
      check(holdStatus == (mHold | mOff), "R6 holdStatus", holdStatus, mHold | mOff);
      check(txOut == (mOn ? txIn : 1'b1), "R2 txOut", txOut, mOn ? txIn : 1'b1);
      check(idleCount == mCnt, "R7 idleCount", idleCount, mCnt);
      check(errClear == mErr, "R6 errClear", errClear, mErr);
      check(recLoad == mLoad, "R7 recLoad", recLoad, mLoad);
    end
    if (cycles > 100000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic sendBits(input int n, input bit v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bitStrobe = 1'b1; rxBit = v; txIn = ~txIn;
      @(negedge clk); bitStrobe = 1'b0;
    end
  endtask

  task automatic writeHold(input bit v);
    @(negedge clk); cfgWrEn = 1'b1; cfgHold = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic pulseBusOff();
    @(negedge clk); busOffEntry = 1'b1;
    @(negedge clk); busOffEntry = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(holdStatus == 1 && busOn == 0 && busOff == 0 && txOut == 1 && idleCount == 0,
          "R1 reset state", {holdStatus, busOn, busOff, txOut}, 4'b1001);
    sendBits(15, 1'b1);
    check(busOn == 0 && txOut == 1, "R2 offline stays recessive", busOn, 0);

    writeHold(1'b0);
    sendBits(10, 1'b1);
    check(busOn == 0, "R3 ten recessive bits not enough", busOn, 0);
    sendBits(1, 1'b0);
    sendBits(10, 1'b1);
    check(busOn == 0, "R3 dominant restarts run", busOn, 0);
    sendBits(1, 1'b1);
    check(busOn == 1, "R4 joined after idle event", busOn, 1);
    sendBits(4, 1'b0);

    writeHold(1'b1);
    check(busOn == 0 && holdStatus == 1, "R5 hold write disconnects", busOn, 0);
    writeHold(1'b0);
    sendBits(11, 1'b1);
    check(busOn == 1, "R4 rejoin after hold release", busOn, 1);

    pulseBusOff();
    check(busOff == 1 && idleCount == 0, "R6 bus-off entered", busOff, 1);
    sendBits(55, 1'b1);
    check(idleCount == 5, "R7 five idle events counted", idleCount, 5);
    pulseBusOff();
    check(idleCount == 5, "R6 repeated entry ignored", idleCount, 5);
    writeHold(1'b0);
    check(holdStatus == 1, "R6 hold reads 1 in bus-off", holdStatus, 1);
    sendBits(11 * 122 + 10, 1'b1);
    check(busOff == 1 && idleCount == 127, "R7 one event short", idleCount, 127);
    sendBits(1, 1'b1);
    check(busOn == 1 && busOff == 0 && idleCount == 128, "R8 immediate join", busOn, 1);

    pulseBusOff();
    sendBits(11 * 128, 1'b1);
    check(busOff == 1 && busOn == 0 && idleCount == 128, "R9 waiting on hold", busOff, 1);
    sendBits(33, 1'b1);
    check(busOn == 0 && idleCount == 128, "R9 extra events do not join", busOn, 0);
    sendBits(5, 1'b1);
    writeHold(1'b0);
    sendBits(10, 1'b1);
    check(busOn == 0, "R9 run restarts on release", busOn, 0);
    sendBits(1, 1'b1);
    check(busOn == 1 && busOff == 0, "R9 joined after release", busOn, 1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule